// File: doc/BRIEF.md
# Masked Priority Interrupt Arbiter

This block chooses which pending interrupt goes to the processor. It takes one non-maskable request and a set of maskable external requests. Each maskable request has a programmable 4-bit priority. The block compares the winning candidate against the processor's current 4-bit mask level. It then presents a request line, the identity of the chosen source and that source's level. The whole selection path is combinational, so the outputs follow the inputs and the registers in the same cycle.

When the processor takes the interrupt it raises an acknowledge input. In that same cycle the block pulses a one-hot accept line to the winning source. On the next clock edge it reloads the mask. The new value is 15 for the non-maskable source, and the accepted source's own priority for a maskable one. Software can also write the mask directly, for example to restore it when leaving a handler. Edge or level detection at the pins is done upstream of this block.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset the mask reads 15, every priority field reads 0, and no request is presented.
- R2: A cycle with `prio_we_i` high loads the priority register from `prio_wdata_i`. The field for pin k sits at bits [4k+3:4k], and the new value appears on `prio_o` after the clock edge.
- R3: An active `nmi_req_i` always wins at level 16 with source ID 4, whatever the mask and whatever maskable requests are pending.
- R4: A maskable pin whose priority field is 0 never produces a request, even when the mask is 0.
- R5: A maskable pin is eligible only while its priority is strictly greater than the current mask.
- R6: Among eligible pins, the one with the highest priority wins. `int_src_o` gives its pin index and `int_lvl_o` its priority.
- R7: When eligible pins share the highest priority, the lowest pin index wins.
- R8: While `ack_i` and `int_req_o` are both high, `accept_o` has exactly one bit set, in the same cycle. Bit k marks pin k and bit 4 marks the non-maskable source. In every other cycle `accept_o` is 0.
- R9: Accepting the non-maskable source sets the mask to 15 after the clock edge.
- R10: Accepting a maskable pin sets the mask to that pin's priority after the clock edge.
- R11: A cycle with `mask_we_i` high loads `mask_wdata_i` into the mask. If an acceptance happens in the same cycle, the acceptance value is loaded instead.
- R12: With nothing eligible, `int_req_o`, `int_src_o` and `int_lvl_o` are all 0, and `ack_i` leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_req_i | input | 1 | Non-maskable request |
| irq_req_i | input | 4 | Maskable requests, one per pin |
| prio_we_i | input | 1 | Priority register write enable |
| prio_wdata_i | input | 16 | Priority fields, 4 bits per pin |
| mask_we_i | input | 1 | Direct mask write enable |
| mask_wdata_i | input | 4 | Direct mask write value |
| ack_i | input | 1 | Processor acknowledge |
| int_req_o | output | 1 | Interrupt request to the processor |
| int_src_o | output | 3 | Winning source ID (pin index, 4 for non-maskable) |
| int_lvl_o | output | 5 | Winning level, 0 to 16 |
| accept_o | output | 5 | One-hot accept pulse to the winning source |
| mask_o | output | 4 | Current mask level |
| prio_o | output | 16 | Current priority register |

## Verification
Selection is combinational, so a fault in the comparison or the tie-break shows up on `int_src_o` and `int_lvl_o` in the same cycle that the inputs change. A mask register that loads the wrong value on acceptance shows up one edge later, as `mask_o` and as a changed set of eligible pins. The directed cases therefore check the outputs both right after a change to the inputs and right after the following edge. They pay particular attention to the strict-greater boundary and to equal-priority ties.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned DEF_N_IRQ = 4;
  localparam int unsigned DEF_LVL_W = 4;
endpackage

// File: rtl/irq_eligible.sv
module irq_eligible #(
  parameter int unsigned N_IRQ = 4,
  parameter int unsigned LVL_W = 4
) (
  input  logic [N_IRQ-1:0]       req_i,
  input  logic [N_IRQ*LVL_W-1:0] prio_i,
  input  logic [LVL_W-1:0]       mask_i,
  output logic [N_IRQ-1:0]       elig_o
);
  for (genvar k = 0; k < N_IRQ; k++) begin : g_cmp
    logic [LVL_W-1:0] lvl;
    assign lvl       = prio_i[k*LVL_W +: LVL_W];
    // zero priority masks the pin; otherwise must strictly beat the mask
    assign elig_o[k] = req_i[k] && (lvl != '0) && (lvl > mask_i);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N_IRQ = 4,
  parameter int unsigned LVL_W = 4,
  localparam int unsigned SRC_W = $clog2(N_IRQ + 1),
  localparam int unsigned OUT_W = LVL_W + 1
) (
  input  logic                   nmi_i,
  input  logic [N_IRQ-1:0]       elig_i,
  input  logic [N_IRQ*LVL_W-1:0] prio_i,
  output logic                   valid_o,
  output logic [SRC_W-1:0]       src_o,
  output logic [OUT_W-1:0]       lvl_o
);
  localparam logic [OUT_W-1:0] NMI_LVL = OUT_W'(1) << LVL_W;
  localparam logic [SRC_W-1:0] NMI_ID  = SRC_W'(N_IRQ);

  logic             found;
  logic [LVL_W-1:0] best_lvl;
  logic [SRC_W-1:0] best_idx;

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    // ascending scan with strict compare keeps the lower index on ties
    for (int k = 0; k < N_IRQ; k++) begin
      if (elig_i[k] && (!found || prio_i[k*LVL_W +: LVL_W] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = prio_i[k*LVL_W +: LVL_W];
        best_idx = SRC_W'(k);
      end
    end
  end

  always_comb begin
    if (nmi_i) begin
      valid_o = 1'b1;
      src_o   = NMI_ID;
      lvl_o   = NMI_LVL;
    end else begin
      valid_o = found;
      src_o   = best_idx;
      lvl_o   = {1'b0, best_lvl};
    end
  end
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
  parameter int unsigned N_IRQ = 4,
  parameter int unsigned LVL_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   prio_we_i,
  input  logic [N_IRQ*LVL_W-1:0] prio_wdata_i,
  input  logic                   load_i,
  input  logic [LVL_W-1:0]       load_val_i,
  input  logic                   mask_we_i,
  input  logic [LVL_W-1:0]       mask_wdata_i,
  output logic [N_IRQ*LVL_W-1:0] prio_o,
  output logic [LVL_W-1:0]       mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        prio_o <= '0;
    else if (prio_we_i) prio_o <= prio_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_o <= '1;
    else if (load_i)    mask_o <= load_val_i;   // acceptance beats software write
    else if (mask_we_i) mask_o <= mask_wdata_i;
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_IRQ = DEF_N_IRQ,
  parameter int unsigned LVL_W = DEF_LVL_W,
  localparam int unsigned SRC_W = $clog2(N_IRQ + 1),
  localparam int unsigned OUT_W = LVL_W + 1,
  localparam int unsigned PR_W  = N_IRQ * LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_req_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic             prio_we_i,
  input  logic [PR_W-1:0]  prio_wdata_i,
  input  logic             mask_we_i,
  input  logic [LVL_W-1:0] mask_wdata_i,
  input  logic             ack_i,
  output logic             int_req_o,
  output logic [SRC_W-1:0] int_src_o,
  output logic [OUT_W-1:0] int_lvl_o,
  output logic [N_IRQ:0]   accept_o,
  output logic [LVL_W-1:0] mask_o,
  output logic [PR_W-1:0]  prio_o
);
  localparam logic [SRC_W-1:0] NMI_ID = SRC_W'(N_IRQ);

  logic [N_IRQ-1:0] elig;
  logic             take;
  logic [LVL_W-1:0] load_val;

  irq_eligible #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_elig (
    .req_i (irq_req_i),
    .prio_i(prio_o),
    .mask_i(mask_o),
    .elig_o(elig)
  );

  irq_pick #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_pick (
    .nmi_i  (nmi_req_i),
    .elig_i (elig),
    .prio_i (prio_o),
    .valid_o(int_req_o),
    .src_o  (int_src_o),
    .lvl_o  (int_lvl_o)
  );

  assign take     = ack_i && int_req_o;
  assign load_val = (int_src_o == NMI_ID) ? '1 : int_lvl_o[LVL_W-1:0];

  for (genvar k = 0; k <= N_IRQ; k++) begin : g_acc
    assign accept_o[k] = take && (int_src_o == SRC_W'(k));
  end

  irq_state_regs #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prio_we_i   (prio_we_i),
    .prio_wdata_i(prio_wdata_i),
    .load_i      (take),
    .load_val_i  (load_val),
    .mask_we_i   (mask_we_i),
    .mask_wdata_i(mask_wdata_i),
    .prio_o      (prio_o),
    .mask_o      (mask_o)
  );
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int unsigned N_IRQ = 4,
  parameter int unsigned LVL_W = 4,
  localparam int unsigned SRC_W = $clog2(N_IRQ + 1),
  localparam int unsigned OUT_W = LVL_W + 1,
  localparam int unsigned PR_W  = N_IRQ * LVL_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             nmi_req_i,
  input logic             mask_we_i,
  input logic             ack_i,
  input logic             int_req_o,
  input logic [SRC_W-1:0] int_src_o,
  input logic [OUT_W-1:0] int_lvl_o,
  input logic [N_IRQ:0]   accept_o,
  input logic [LVL_W-1:0] mask_o
);
  localparam logic [SRC_W-1:0] NMI_ID  = SRC_W'(N_IRQ);
  localparam logic [OUT_W-1:0] NMI_LVL = OUT_W'(1) << LVL_W;

  AST_NMI_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_i |-> int_req_o && int_src_o == NMI_ID && int_lvl_o == NMI_LVL); // R3
  AST_IRQ_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_o && !nmi_req_i |-> int_lvl_o > {1'b0, mask_o}); // R5
  AST_ACCEPT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(accept_o)); // R8
  AST_ACCEPT_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o != '0 |-> ack_i && int_req_o); // R8
  AST_MASK_AFTER_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && nmi_req_i |=> mask_o == '1); // R9
  AST_MASK_AFTER_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && int_req_o && !nmi_req_i |=> mask_o == $past(int_lvl_o[LVL_W-1:0])); // R10
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && int_req_o) && !mask_we_i |=> $stable(mask_o)); // R12
  AST_IDLE_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_req_o |-> int_src_o == '0 && int_lvl_o == '0 && accept_o == '0); // R12
endmodule

bind irq_prio_arbiter irq_arb_checker #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .nmi_req_i(nmi_req_i),
  .mask_we_i(mask_we_i),
  .ack_i    (ack_i),
  .int_req_o(int_req_o),
  .int_src_o(int_src_o),
  .int_lvl_o(int_lvl_o),
  .accept_o (accept_o),
  .mask_o   (mask_o)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi = 1'b0;
  logic [3:0]  irq = '0;
  logic        prio_we = 1'b0;
  logic [15:0] prio_wd = '0;
  logic        mask_we = 1'b0;
  logic [3:0]  mask_wd = '0;
  logic        ack = 1'b0;
  logic        req;
  logic [2:0]  src;
  logic [4:0]  lvl;
  logic [4:0]  acc;
  logic [3:0]  mask;
  logic [15:0] prio;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_prio_arbiter u_irq_prio_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .nmi_req_i(nmi), .irq_req_i(irq),
    .prio_we_i(prio_we), .prio_wdata_i(prio_wd), .mask_we_i(mask_we),
    .mask_wdata_i(mask_wd), .ack_i(ack), .int_req_o(req), .int_src_o(src),
    .int_lvl_o(lvl), .accept_o(acc), .mask_o(mask), .prio_o(prio)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive after negedge, settle, sample comb outputs
  task automatic settle();
    @(negedge clk); #2;
  endtask

  // let one posedge pass, sample registered outputs away from edge
  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic set_mask(logic [3:0] v);
    @(negedge clk); mask_we = 1'b1; mask_wd = v;
    tick(); mask_we = 1'b0;
    chk("R11 mask write", 32'(mask), 32'(v));
  endtask

  task automatic set_prio(logic [15:0] v);
    @(negedge clk); prio_we = 1'b1; prio_wd = v;
    tick(); prio_we = 1'b0;
    chk("R2 prio write", 32'(prio), 32'(v));
  endtask

  task automatic t_reset();
    chk("R1 mask", 32'(mask), 32'd15);
    chk("R1 prio", 32'(prio), 32'd0);
    chk("R1 req", 32'(req), 32'd0);
  endtask

  task automatic t_zero_prio();
    set_prio({4'd5, 4'd5, 4'd0, 4'd2});
    set_mask(4'd0);
    @(negedge clk); irq = 4'b0010; #2;
    chk("R4 zero prio req", 32'(req), 32'd0);
    chk("R12 idle src", 32'(src), 32'd0);
    chk("R12 idle lvl", 32'(lvl), 32'd0);
    ack = 1'b1; #1;
    chk("R8 no accept idle", 32'(acc), 32'd0);
    tick(); ack = 1'b0;
    chk("R12 ack ignored mask", 32'(mask), 32'd0);
  endtask

  task automatic t_select();
    @(negedge clk); irq = 4'b0001; #2;
    chk("R6 single src", 32'(src), 32'd0);
    chk("R6 single lvl", 32'(lvl), 32'd2);
    @(negedge clk); irq = 4'b1101; #2;
    chk("R7 tie src", 32'(src), 32'd2);
    chk("R6 tie lvl", 32'(lvl), 32'd5);
    chk("R8 no ack no accept", 32'(acc), 32'd0);
  endtask

  task automatic t_strict();
    set_mask(4'd5);
    @(negedge clk); irq = 4'b1101; #2;
    chk("R5 equal to mask blocked", 32'(req), 32'd0);
    set_mask(4'd4);
    settle();
    chk("R5 above mask req", 32'(req), 32'd1);
    chk("R5 above mask src", 32'(src), 32'd2);
  endtask

  task automatic t_nmi();
    set_mask(4'd0);
    @(negedge clk); irq = 4'b1111; nmi = 1'b1; #2;
    chk("R3 nmi req", 32'(req), 32'd1);
    chk("R3 nmi src", 32'(src), 32'd4);
    chk("R3 nmi lvl", 32'(lvl), 32'd16);
    ack = 1'b1; #1;
    chk("R8 nmi accept", 32'(acc), 32'b10000);
    tick(); ack = 1'b0;
    chk("R9 mask after nmi", 32'(mask), 32'd15);
    settle();
    chk("R3 nmi beats mask 15", 32'(src), 32'd4);
    nmi = 1'b0; irq = '0;
  endtask

  task automatic t_irq_accept();
    set_prio({4'd9, 4'd5, 4'd0, 4'd2});
    set_mask(4'd0);
    @(negedge clk); irq = 4'b1111; #2;
    chk("R6 highest src", 32'(src), 32'd3);
    chk("R6 highest lvl", 32'(lvl), 32'd9);
    ack = 1'b1; #1;
    chk("R8 irq accept", 32'(acc), 32'b01000);
    tick(); ack = 1'b0;
    chk("R10 mask after irq", 32'(mask), 32'd9);
    settle();
    chk("R5 masked after accept", 32'(req), 32'd0);
    irq = '0;
  endtask

  task automatic t_ack_vs_write();
    set_mask(4'd0);
    @(negedge clk); irq = 4'b0100; ack = 1'b1; mask_we = 1'b1; mask_wd = 4'd3;
    tick(); ack = 1'b0; mask_we = 1'b0;
    chk("R11 accept beats write", 32'(mask), 32'd5);
    irq = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2; t_reset();
    rst_n = 1'b1;
    settle();
    t_zero_prio();
    t_select();
    t_strict();
    t_nmi();
    t_irq_accept();
    t_ack_vs_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule